// File: doc/BRIEF.md
# Masked GPIO Register Controller

This block controls 23 tri-state digital lines through a 16-bit register bus that takes one access per cycle. Each line has a direction latch and an output latch. A line set as an output drives its output latch onto the pad. A line set as an input is left undriven. Every value read back from the pads comes from a two-stage synchronizer, so the output latches themselves are never visible on the bus.

There are three ways to reach the lines. The first is a per-line register. Writing it turns the line into an output, and reading it turns the line into an input. The second is a set of bank-wide registers for direction and level, gated by a separate readable inhibit mask. The third is a set of port registers, each covering one group of up to eight lines. A write to a port register carries its inhibit mask in the upper byte.

A read answers one cycle after the request with a valid strobe. An access to an address that no register occupies returns zero and raises a one-cycle error flag.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every `pad_oe` and `pad_out` bit is 0, `bus_rvalid` and `bus_err` are 0, and the inhibit register reads as 0.
- R2: A write to address 2000+N (N = 0..22) makes line N an output with `pad_out[N]` equal to `bus_wdata[0]`, visible in the cycle after the request edge, regardless of the inhibit mask.
- R3: A read of address 2000+N returns the synchronized pad level of line N in data bit 0, with bits 15:1 zero, and line N becomes an input.
- R4: The inhibit mask is 23 bits wide: address 2100 holds lines 15:0 in data bits 15:0, and address 2101 holds lines 22:16 in data bits 6:0. It is written without masking and reads back what was written, with unused bits reading 0.
- R5: Bank direction (2102 low, 2103 high) and bank level (2104 low, 2105 high) use the same half split as R4. A write changes only those bits whose inhibit bit is 0. Direction 1 means output.
- R6: A read of the bank level halves returns synchronized pad levels and changes no direction. A read of the bank direction halves returns the direction latches.
- R7: Port p (0 = lines 0..7, 1 = lines 8..15, 2 = lines 16..19, 3 = lines 20..22) has a direction register at 2110+2p and a level register at 2111+2p, with the port's lowest line in bit 0. In a write, bit 8+k set leaves port bit k unchanged, and bits 7:0 are the new values.
- R8: A port direction read returns the port's direction bits, and a port level read returns its synchronized pad levels. Bits with no line behind them and bits 15:8 read 0. Writes to such bits change nothing.
- R9: `pad_oe` equals the direction latches. `pad_out` equals the output latch on output lines and 0 on input lines.
- R10: A pad change is returned by a read whose request is sampled on the third rising edge after the change or later. A request sampled on the second edge still returns the old level.
- R11: An access to any other address returns data 0, leaves all latches unchanged, and raises `bus_err` for exactly the cycle after the request edge.
- R12: `bus_rvalid` is high for exactly the cycle after a read request edge, and low after writes and idle cycles. `bus_rdata` is 0 whenever `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read response strobe |
| bus_err | output | 1 | Unmapped-address strobe |
| pad_in | input | 23 | Raw pad levels |
| pad_oe | output | 23 | Per-line output enable |
| pad_out | output | 23 | Per-line driven level |

## Verification
The per-line read does two things at the same edge: it returns the pad level and it clears that line's direction. These two collide when the line being read is an output whose pad is held at the opposite level, as if shorted externally. The bench forces that case by writing a line high, driving its pad low, and letting the synchronizer settle before the read. It then expects the read to return 0 rather than the latched 1, and expects `pad_oe` for that line to drop in the same response cycle. Random traffic repeats the collision on arbitrary lines whenever a random pad pattern disagrees with the output latches.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NLINES = 23;
  localparam int DW     = 16;
  localparam int NPORTS = 4;

  typedef enum logic [2:0] {
    A_NONE, A_LINE, A_INH, A_DIR, A_STATE, A_PDIR, A_PSTATE, A_BAD
  } acc_kind_e;

  // idx carries the line number, the half select (bit 0) or the port number (bits 1:0)
  typedef struct packed {
    acc_kind_e   kind;
    logic [4:0]  idx;
  } acc_t;

  function automatic int port_lo(input logic [1:0] p);
    case (p)
      2'd0: return 0;
      2'd1: return 8;
      2'd2: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic int port_len(input logic [1:0] p);
    case (p)
      2'd0, 2'd1: return 8;
      2'd2: return 4;
      default: return 3;
    endcase
  endfunction

  function automatic logic [NLINES-1:0] port_mask(input logic [1:0] p);
    logic [NLINES-1:0] m;
    int lo, len;
    lo = port_lo(p);
    len = port_len(p);
    m = '0;
    for (int i = 0; i < NLINES; i++)
      if (i >= lo && i < lo + len) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [NLINES-1:0] port_place(input logic [1:0] p, input logic [7:0] b);
    logic [NLINES-1:0] v;
    int lo, len;
    lo = port_lo(p);
    len = port_len(p);
    v = '0;
    for (int i = 0; i < NLINES; i++)
      if (i >= lo && i < lo + len) v[i] = b[i-lo];
    return v;
  endfunction

  function automatic logic [7:0] port_take(input logic [1:0] p, input logic [NLINES-1:0] vec);
    logic [7:0] b;
    int lo, len;
    lo = port_lo(p);
    len = port_len(p);
    b = '0;
    for (int j = 0; j < 8; j++)
      if (j < len) b[j] = vec[lo+j];
    return b;
  endfunction

  function automatic logic [NLINES-1:0] half_mask(input logic h);
    return h ? {7'h7f, 16'h0000} : {7'h00, 16'hffff};
  endfunction

  function automatic logic [NLINES-1:0] half_place(input logic h, input logic [DW-1:0] d);
    return h ? {d[6:0], 16'h0000} : {7'h00, d};
  endfunction

  function automatic logic [DW-1:0] half_take(input logic h, input logic [NLINES-1:0] vec);
    return h ? {9'd0, vec[22:16]} : vec[15:0];
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 23,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter logic [15:0] LINE_BASE = 16'd2000,
  parameter logic [15:0] BANK_BASE = 16'd2100,
  parameter logic [15:0] PORT_BASE = 16'd2110
) (
  input  logic        req,
  input  logic [15:0] addr,
  output acc_t        acc
);
  localparam logic [15:0] LINE_END = LINE_BASE + 16'(NLINES);
  localparam logic [15:0] BANK_END = BANK_BASE + 16'd6;
  localparam logic [15:0] PORT_END = PORT_BASE + 16'(2*NPORTS);

  logic [15:0] off_line, off_bank, off_port;
  assign off_line = addr - LINE_BASE;
  assign off_bank = addr - BANK_BASE;
  assign off_port = addr - PORT_BASE;

  always_comb begin
    acc.kind = A_NONE;
    acc.idx  = '0;
    if (req) begin
      if (addr >= LINE_BASE && addr < LINE_END) begin
        acc.kind = A_LINE;
        acc.idx  = off_line[4:0];
      end else if (addr >= BANK_BASE && addr < BANK_END) begin
        case (off_bank[2:1])
          2'd0:    acc.kind = A_INH;
          2'd1:    acc.kind = A_DIR;
          default: acc.kind = A_STATE;
        endcase
        acc.idx = {4'd0, off_bank[0]};
      end else if (addr >= PORT_BASE && addr < PORT_END) begin
        acc.kind = off_port[0] ? A_PSTATE : A_PDIR;
        acc.idx  = {3'd0, off_port[2:1]};
      end else begin
        acc.kind = A_BAD;
      end
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output logic [NLINES-1:0] dir,
  output logic [NLINES-1:0] st,
  output logic [NLINES-1:0] inh
);
  logic [NLINES-1:0] dir_sel, dir_val, st_sel, st_val, inh_sel, inh_val;
  logic [NLINES-1:0] line_bit, port_inh, port_blocked;
  logic              bank_wr, port_wr;

  assign line_bit     = NLINES'(1) << acc.idx;
  assign port_inh     = port_place(acc.idx[1:0], wdata[15:8]);
  assign port_blocked = port_inh | ~port_mask(acc.idx[1:0]);
  assign bank_wr      = we && (acc.kind == A_DIR || acc.kind == A_STATE);
  assign port_wr      = we && (acc.kind == A_PDIR || acc.kind == A_PSTATE);

  always_comb begin
    dir_sel = '0; dir_val = '0;
    st_sel  = '0; st_val  = '0;
    inh_sel = '0; inh_val = '0;
    case (acc.kind)
      A_LINE: begin
        dir_sel = line_bit;
        dir_val = we ? '1 : '0;
        if (we) begin
          st_sel = line_bit;
          st_val = {NLINES{wdata[0]}};
        end
      end
      A_INH: if (we) begin
        inh_sel = half_mask(acc.idx[0]);
        inh_val = half_place(acc.idx[0], wdata);
      end
      A_DIR: if (we) begin
        dir_sel = half_mask(acc.idx[0]) & ~inh;
        dir_val = half_place(acc.idx[0], wdata);
      end
      A_STATE: if (we) begin
        st_sel = half_mask(acc.idx[0]) & ~inh;
        st_val = half_place(acc.idx[0], wdata);
      end
      A_PDIR: if (we) begin
        dir_sel = ~port_blocked;
        dir_val = port_place(acc.idx[1:0], wdata[7:0]);
      end
      A_PSTATE: if (we) begin
        st_sel = ~port_blocked;
        st_val = port_place(acc.idx[1:0], wdata[7:0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0;
      st  <= '0;
      inh <= '0;
    end else begin
      dir <= (dir & ~dir_sel) | (dir_val & dir_sel);
      st  <= (st  & ~st_sel)  | (st_val  & st_sel);
      inh <= (inh & ~inh_sel) | (inh_val & inh_sel);
    end
  end

  // R5: inhibited bits hold through bank-wide writes
  assert_bank_inhibit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> (((dir ^ $past(dir)) | (st ^ $past(st))) & $past(inh)) == '0);

  // R7, R8: port writes touch only uninhibited, mapped bits of that port
  assert_port_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (((dir ^ $past(dir)) | (st ^ $past(st))) & $past(port_blocked)) == '0);

  // R4: inhibit mask moves only on a write to its own halves
  assert_inhibit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && acc.kind == A_INH) |=> $stable(inh));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter logic [15:0] LINE_BASE   = 16'd2000,
  parameter logic [15:0] BANK_BASE   = 16'd2100,
  parameter logic [15:0] PORT_BASE   = 16'd2110,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_oe,
  output logic [NLINES-1:0] pad_out
);
  acc_t              acc;
  logic [NLINES-1:0] dir, st, inh, pad_s;
  logic [DW-1:0]     rd_mux;
  logic              rd_fire, bad_hit, line_wr, line_rd;

  gpio_decode #(
    .LINE_BASE(LINE_BASE), .BANK_BASE(BANK_BASE), .PORT_BASE(PORT_BASE)
  ) u_dec (
    .req(bus_req), .addr(bus_addr), .acc(acc)
  );

  gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .we(bus_we), .wdata(bus_wdata),
    .dir(dir), .st(st), .inh(inh)
  );

  gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
  );

  assign rd_fire = bus_req && !bus_we;
  assign bad_hit = (acc.kind == A_BAD);
  assign line_wr = (acc.kind == A_LINE) && bus_we;
  assign line_rd = (acc.kind == A_LINE) && !bus_we;

  always_comb begin
    case (acc.kind)
      A_LINE:   rd_mux = {15'd0, pad_s[acc.idx]};
      A_INH:    rd_mux = half_take(acc.idx[0], inh);
      A_DIR:    rd_mux = half_take(acc.idx[0], dir);
      A_STATE:  rd_mux = half_take(acc.idx[0], pad_s);
      A_PDIR:   rd_mux = {8'd0, port_take(acc.idx[1:0], dir)};
      A_PSTATE: rd_mux = {8'd0, port_take(acc.idx[1:0], pad_s)};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rdata  <= rd_fire ? rd_mux : '0;
      bus_rvalid <= rd_fire;
      bus_err    <= bad_hit;
    end
  end

  assign pad_oe  = dir;
  assign pad_out = dir & st;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && !bus_rvalid && !bus_err));

  assert_line_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr |=> (pad_oe[$past(acc.idx)] && pad_out[$past(acc.idx)] == $past(bus_wdata[0])));

  assert_line_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_rd |=> (!pad_oe[$past(acc.idx)] && bus_rdata[15:1] == '0));

  assert_port_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && (acc.kind == A_PDIR || acc.kind == A_PSTATE)) |=> bus_rdata[15:8] == '0);

  assert_bad_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_hit |=> (bus_err && bus_rdata == '0 && $stable(pad_oe) && $stable(pad_out)));

  assert_rvalid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> (!bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid, bus_err;
  logic [22:0] pad_in, pad_oe, pad_out;

  logic [22:0] m_dir = '0, m_st = '0, m_inh = '0, m_pad = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign pad_in = m_pad;
  always #5 clk = ~clk;

  gpio_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int plo(input int p);
    return (p == 0) ? 0 : (p == 1) ? 8 : (p == 2) ? 16 : 20;
  endfunction
  function automatic int plen(input int p);
    return (p < 2) ? 8 : (p == 2) ? 4 : 3;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_op(input logic w, input logic [15:0] a, input logic [15:0] d);
    logic [15:0] rd, exp_rd;
    logic er, rv, exp_er;
    string tag;
    int off, n, base, cnt, p, b;
    exp_rd = '0; exp_er = 1'b0;
    if (a >= 16'd2000 && a <= 16'd2022) begin
      n = int'(a) - 2000;
      if (w) begin tag = "R2"; m_dir[n] = 1'b1; m_st[n] = d[0]; end
      else begin tag = "R3"; exp_rd = {15'd0, m_pad[n]}; m_dir[n] = 1'b0; end
    end else if (a >= 16'd2100 && a <= 16'd2105) begin
      off = int'(a) - 2100;
      base = (off % 2 == 1) ? 16 : 0;
      cnt  = (off % 2 == 1) ? 7 : 16;
      tag = (off < 2) ? "R4" : (w ? "R5" : "R6");
      for (int k = 0; k < cnt; k++) begin
        b = base + k;
        if (w) begin
          if (off / 2 == 0) m_inh[b] = d[k];
          else if (!m_inh[b]) begin
            if (off / 2 == 1) m_dir[b] = d[k]; else m_st[b] = d[k];
          end
        end else begin
          exp_rd[k] = (off / 2 == 0) ? m_inh[b] : (off / 2 == 1) ? m_dir[b] : m_pad[b];
        end
      end
    end else if (a >= 16'd2110 && a <= 16'd2117) begin
      off = int'(a) - 2110;
      p = off / 2;
      tag = w ? "R7" : "R8";
      for (int k = 0; k < plen(p); k++) begin
        b = plo(p) + k;
        if (w) begin
          if (!d[8+k]) begin
            if (off % 2 == 1) m_st[b] = d[k]; else m_dir[b] = d[k];
          end
        end else begin
          exp_rd[k] = (off % 2 == 1) ? m_pad[b] : m_dir[b];
        end
      end
    end else begin
      tag = "R11";
      exp_er = 1'b1;
    end
    @(negedge clk);
    bus_req = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0;
    rd = bus_rdata; er = bus_err; rv = bus_rvalid;
    check(rd == (w ? 16'd0 : exp_rd), {tag, " rdata"}, 32'(rd), 32'(w ? 16'd0 : exp_rd));
    check(er == exp_er, {tag, " R11 err"}, 32'(er), 32'(exp_er));
    check(rv == !w, {tag, " R12 rvalid"}, 32'(rv), 32'(!w));
    check(pad_oe == m_dir, {tag, " R9 pad_oe"}, 32'(pad_oe), 32'(m_dir));
    check(pad_out == (m_dir & m_st), {tag, " R9 pad_out"}, 32'(pad_out), 32'(m_dir & m_st));
  endtask

  task automatic set_pads(input logic [22:0] v);
    m_pad = v;
    idle(2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    logic [15:0] a;
    seed_dummy = int'($urandom(32'h5eed));
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(pad_oe == '0, "R1 pad_oe", 32'(pad_oe), 0);
    check(pad_out == '0, "R1 pad_out", 32'(pad_out), 0);
    check(!bus_rvalid && !bus_err, "R1 strobes", 32'({bus_rvalid, bus_err}), 0);
    do_op(1'b0, 16'd2100, 16'd0);   // R1 inhibit low half reads 0
    do_op(1'b0, 16'd2101, 16'd0);   // R1 inhibit high half reads 0

    // R2 then R3 with the pad opposing the latch
    do_op(1'b1, 16'd2004, 16'd1);
    set_pads(23'h0);
    do_op(1'b0, 16'd2004, 16'd0);   // returns 0, line 4 drops to input
    do_op(1'b1, 16'd2022, 16'hfffe); // R2 bit 0 only

    // R4/R5: only lines 4 and 5 free
    do_op(1'b1, 16'd2100, 16'hffcf);
    do_op(1'b1, 16'd2101, 16'h007f);
    do_op(1'b1, 16'd2102, 16'hffff);
    do_op(1'b1, 16'd2104, 16'h0030);
    do_op(1'b1, 16'd2103, 16'h0000);
    do_op(1'b0, 16'd2102, 16'd0);
    do_op(1'b0, 16'd2101, 16'd0);
    do_op(1'b1, 16'd2100, 16'h0000);
    do_op(1'b1, 16'd2101, 16'h0000);

    // R7/R8 ports
    do_op(1'b1, 16'd2110, 16'h01ff);
    do_op(1'b1, 16'd2115, 16'h00ff);
    do_op(1'b1, 16'd2114, 16'h00ff);
    do_op(1'b0, 16'd2114, 16'd0);
    do_op(1'b1, 16'd2116, 16'hffff);
    do_op(1'b0, 16'd2117, 16'd0);

    // R10 synchronizer latency
    @(negedge clk);
    m_pad = 23'h2aaaaa;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'd2104;
    @(negedge clk);
    check(bus_rdata == 16'h0000, "R10 old level", 32'(bus_rdata), 0);
    @(negedge clk);
    check(bus_rdata == 16'h0000, "R10 still old", 32'(bus_rdata), 0);
    @(negedge clk);
    check(bus_rdata == 16'haaaa, "R10 new level", 32'(bus_rdata), 32'haaaa);
    bus_req = 1'b0;
    idle(1);

    // R11 unmapped
    do_op(1'b0, 16'd2023, 16'd0);
    do_op(1'b1, 16'd2106, 16'hffff);
    do_op(1'b1, 16'd2118, 16'hffff);
    do_op(1'b0, 16'd0, 16'd0);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0) set_pads(23'($urandom));
      case ($urandom_range(0, 4))
        0, 1: a = 16'(2000 + $urandom_range(0, 22));
        2:    a = 16'(2100 + $urandom_range(0, 5));
        3:    a = 16'(2110 + $urandom_range(0, 7));
        default: case ($urandom_range(0, 3))
          0: a = 16'd1999;
          1: a = 16'd2023;
          2: a = 16'd2109;
          default: a = 16'd2118;
        endcase
      endcase
      do_op(1'($urandom_range(0, 1)), a, 16'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule